// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit half of a packet interface that shares a circular array of buffer descriptors with a host processor. Each descriptor carries a buffer address, a length and an ownership flag. The host posts work through a single write port. Each accepted post fills the descriptor at the producer index, marks it as owned by hardware, and advances the producer index. The index wraps at the end of the array. A post is refused while the slot under the producer index is still owned by hardware, which is how the ring reports that it is full.

On the other side, a consumer engine takes hardware-owned descriptors strictly in ring order. It presents each one on a request interface and holds it there until a done pulse arrives. It then hands the slot back to the host and advances its own index. If the following slot is already owned, the next request starts in the very next cycle. Otherwise the engine goes idle and re-reads the slot under its index once per programmable polling interval. Work posted to an empty ring therefore waits up to one full interval.

An interrupt line reports progress to the host in one of two selectable ways. It can fire on every completed packet, or only when the number of hardware-owned descriptors drops to a programmable low-water mark. A write-one-to-clear strobe lowers it.

Top module: `txring_engine`

## Requirements
- R1: After reset every descriptor is host-owned, both indices are zero and the engine is idle: `postReady` is 1, `txReqValid` is 0 and `irq` is 0.
- R2: A post is accepted when `postValid` and `postReady` are both 1 at a clock edge. It stores `postAddr`/`postLen` in the slot at the producer index, marks that slot hardware-owned and advances the producer index modulo DEPTH.
- R3: `postReady` is 0 while the slot at the producer index is hardware-owned, which happens after DEPTH posts with no completion. A post offered then changes no descriptor and no index.
- R4: Requests carry the descriptors in exactly the order they were posted, across wrap-around. While `txReqValid` is 1 and `txDone` is 0, `txReqValid`, `txReqAddr` and `txReqLen` hold steady.
- R5: A completion (`txDone` while `txReqValid`) returns the slot to the host. If the next slot is hardware-owned at that edge, `txReqValid` stays 1 in the next cycle with that slot's fields, leaving no idle cycle.
- R6: When the engine goes idle after a completion, it reads the slot at its index once every `cfgPollInterval` cycles (a value of 0 acts as 1). If a descriptor is posted in the first cycle after that completion and the interval is at least 2, `txReqValid` is low for exactly `cfgPollInterval` cycles before the request appears.
- R7: With `cfgIrqRefill` = 0, `irq` becomes 1 in the cycle after every completion.
- R8: With `cfgIrqRefill` = 1, `irq` becomes 1 only after a completion that moves the count of hardware-owned descriptors from above `cfgLowWater` to at or below it.
- R9: A one-cycle pulse on `irqClr` drops `irq` at the next edge. A completion that sets the interrupt in the same cycle wins over the clear.
- R10: `txDone` while `txReqValid` is 0 is ignored. It raises no interrupt and does not advance the consumer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| postValid | input | 1 | Host offers a descriptor |
| postAddr | input | ADDR_W | Buffer address of offered descriptor |
| postLen | input | LEN_W | Byte length of offered descriptor |
| postReady | output | 1 | Slot at producer index is host-owned |
| cfgPollInterval | input | POLL_W | Idle polling period in cycles |
| cfgIrqRefill | input | 1 | 0: interrupt per packet, 1: interrupt at low-water |
| cfgLowWater | input | $clog2(DEPTH)+1 | Low-water count of hardware-owned descriptors |
| irqClr | input | 1 | Write-one-to-clear strobe for the interrupt |
| irq | output | 1 | Interrupt request |
| txReqValid | output | 1 | A descriptor is presented to the transmitter |
| txReqAddr | output | ADDR_W | Address of presented descriptor |
| txReqLen | output | LEN_W | Length of presented descriptor |
| txDone | input | 1 | Transmitter finished the presented descriptor |

## Verification
The bench sweeps the polling interval across its practical range and measures the exact idle gap each time. An off-by-one in the poll counter shows up as a gap one cycle long or short. The same sweep wraps a four-entry ring many times, so an index that wraps wrongly or skips a slot produces a wrong address. Other checks fill the ring and then offer one more post. An engine that overwrites a live slot would send the bogus address, and one that drops a completion-time look-ahead would leave a hole between back-to-back packets. The low-water mark is swept over every value: an edge-triggered comparison written as a level would fire repeatedly, and one written with the wrong inequality would fire a packet early or late. Further checks cover a clear that arrives together with a new completion, and stray done pulses that must not advance the consumer.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_SEND = 1'b1
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic complete;   // presented descriptor finished this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postValid,
  input  logic [ADDR_W-1:0] postAddr,
  input  logic [LEN_W-1:0]  postLen,
  output logic              postReady,
  output logic              postFire,
  input  ctrlStrobe_t       strobe,
  output logic              ownCur,
  output logic              ownNext,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  curLen,
  output logic [CNT_W-1:0]  hwCount
);

  generate
    if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_badDepth
      $error("DEPTH must be a power of two, at least 2");
    end
  endgenerate

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [LEN_W-1:0]  lenMem  [DEPTH];
  logic [DEPTH-1:0]  ownVec;
  logic [IDX_W-1:0]  prodIdx;
  logic [IDX_W-1:0]  consIdx;
  logic [IDX_W-1:0]  consNextIdx;
  logic [CNT_W-1:0]  hwCountQ;

  assign consNextIdx = consIdx + IDX_W'(1);
  assign postReady   = !ownVec[prodIdx];
  assign postFire    = postValid && !ownVec[prodIdx];

  // one ownership flag and one payload slot per ring entry
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ownVec[i] <= 1'b0;
        end else if (postFire && prodIdx == IDX_W'(i)) begin
          ownVec[i] <= 1'b1;
        end else if (strobe.complete && consIdx == IDX_W'(i)) begin
          ownVec[i] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (postFire && prodIdx == IDX_W'(i)) begin
          addrMem[i] <= postAddr;
          lenMem[i]  <= postLen;
        end
      end
    end
  endgenerate

  // producer/consumer indices wrap naturally at power-of-two depth
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodIdx  <= '0;
      consIdx  <= '0;
      hwCountQ <= '0;
    end else begin
      if (postFire) begin
        prodIdx <= prodIdx + IDX_W'(1);
      end
      if (strobe.complete) begin
        consIdx <= consNextIdx;
      end
      case ({postFire, strobe.complete})
        2'b10:   hwCountQ <= hwCountQ + CNT_W'(1);
        2'b01:   hwCountQ <= hwCountQ - CNT_W'(1);
        default: hwCountQ <= hwCountQ;
      endcase
    end
  end

  assign ownCur  = ownVec[consIdx];
  assign ownNext = ownVec[consNextIdx];
  assign curAddr = addrMem[consIdx];
  assign curLen  = lenMem[consIdx];
  assign hwCount = hwCountQ;

  // running count must agree with the ownership flags
  assert_count_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(hwCountQ) == $countones(ownVec))
    else $error("R2: owned count disagrees with flags");

  assert_full_block_R3: assert property (@(posedge clk) disable iff (!rstN)
    postValid && !postReady |=> $stable(prodIdx))
    else $error("R3: producer moved while ring full");

  assert_cons_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.complete |=> $stable(consIdx))
    else $error("R10: consumer moved without completion");

endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
#(
  parameter int POLL_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [POLL_W-1:0] cfgPollInterval,
  input  logic              cfgIrqRefill,
  input  logic [CNT_W-1:0]  cfgLowWater,
  input  logic              irqClr,
  input  logic              txDone,
  input  logic              ownCur,
  input  logic              ownNext,
  input  logic [CNT_W-1:0]  hwCount,
  input  logic              postFire,
  output ctrlStrobe_t       strobe,
  output logic              txReqValid,
  output logic              irq
);

  engState_t         stateQ, stateD;
  logic [POLL_W-1:0] pollCnt, pollCntD;
  logic              pollHit;
  logic              complete;
  logic [CNT_W-1:0]  hwAfter;
  logic              crossLow;
  logic              irqSet;
  logic              irqQ;

  // an interval of 0 or 1 polls every cycle; >= keeps a shrinking
  // interval from stranding the counter above the new limit
  assign pollHit  = (cfgPollInterval <= POLL_W'(1)) ||
                    (pollCnt >= cfgPollInterval - POLL_W'(1));
  assign complete = (stateQ == ENG_SEND) && txDone;

  always_comb begin
    stateD   = stateQ;
    pollCntD = pollCnt;
    unique case (stateQ)
      ENG_IDLE: begin
        if (pollHit) begin
          pollCntD = '0;
          if (ownCur) begin
            stateD = ENG_SEND;
          end
        end else begin
          pollCntD = pollCnt + POLL_W'(1);
        end
      end
      ENG_SEND: begin
        if (complete) begin
          pollCntD = '0;
          if (!ownNext) begin
            stateD = ENG_IDLE;
          end
        end
      end
      default: begin
        stateD   = ENG_IDLE;
        pollCntD = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ENG_IDLE;
      pollCnt <= '0;
    end else begin
      stateQ  <= stateD;
      pollCnt <= pollCntD;
    end
  end

  // interrupt: per packet, or on crossing down to the low-water mark
  assign hwAfter  = hwCount + CNT_W'(postFire) - CNT_W'(complete);
  assign crossLow = (hwCount > cfgLowWater) && (hwAfter <= cfgLowWater);
  assign irqSet   = complete && (!cfgIrqRefill || crossLow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (irqSet) begin
      irqQ <= 1'b1;
    end else if (irqClr) begin
      irqQ <= 1'b0;
    end
  end

  assign strobe.complete = complete;
  assign txReqValid      = (stateQ == ENG_SEND);
  assign irq             = irqQ;

  assert_send_owned_R4: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ENG_SEND |-> ownCur)
    else $error("R4: presenting a host-owned slot");

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(complete))
    else $error("R7: interrupt without completion");

  assert_per_packet_R7: assert property (@(posedge clk) disable iff (!rstN)
    complete && !cfgIrqRefill |=> irqQ)
    else $error("R7: completion did not interrupt");

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqClr && !complete |=> !irqQ)
    else $error("R9: clear ignored");

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  parameter int POLL_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postValid,
  input  logic [ADDR_W-1:0] postAddr,
  input  logic [LEN_W-1:0]  postLen,
  output logic              postReady,
  input  logic [POLL_W-1:0] cfgPollInterval,
  input  logic              cfgIrqRefill,
  input  logic [CNT_W-1:0]  cfgLowWater,
  input  logic              irqClr,
  output logic              irq,
  output logic              txReqValid,
  output logic [ADDR_W-1:0] txReqAddr,
  output logic [LEN_W-1:0]  txReqLen,
  input  logic              txDone
);

  ctrlStrobe_t      strobe;
  logic             postFire;
  logic             ownCur;
  logic             ownNext;
  logic [CNT_W-1:0] hwCount;

  txring_datapath #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .postValid (postValid),
    .postAddr  (postAddr),
    .postLen   (postLen),
    .postReady (postReady),
    .postFire  (postFire),
    .strobe    (strobe),
    .ownCur    (ownCur),
    .ownNext   (ownNext),
    .curAddr   (txReqAddr),
    .curLen    (txReqLen),
    .hwCount   (hwCount)
  );

  txring_ctrl #(
    .POLL_W (POLL_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .cfgPollInterval (cfgPollInterval),
    .cfgIrqRefill    (cfgIrqRefill),
    .cfgLowWater     (cfgLowWater),
    .irqClr          (irqClr),
    .txDone          (txDone),
    .ownCur          (ownCur),
    .ownNext         (ownNext),
    .hwCount         (hwCount),
    .postFire        (postFire),
    .strobe          (strobe),
    .txReqValid      (txReqValid),
    .irq             (irq)
  );

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid && !txDone |=> txReqValid && $stable(txReqAddr) && $stable(txReqLen))
    else $error("R4: request changed before done");

endmodule

// File: tb/sim_txring_engine.sv
module sim_txring_engine;

  localparam int DEPTH  = 4;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 8;
  localparam int POLL_W = 6;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              postValid = 1'b0;
  logic [ADDR_W-1:0] postAddr = '0;
  logic [LEN_W-1:0]  postLen = '0;
  logic              postReady;
  logic [POLL_W-1:0] cfgPollInterval = POLL_W'(4);
  logic              cfgIrqRefill = 1'b0;
  logic [CNT_W-1:0]  cfgLowWater = '0;
  logic              irqClr = 1'b0;
  logic              irq;
  logic              txReqValid;
  logic [ADDR_W-1:0] txReqAddr;
  logic [LEN_W-1:0]  txReqLen;
  logic              txDone = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int seq = 0;

  always #2 clk = ~clk;   // 4 ns period

  txring_engine #(
    .DEPTH (DEPTH), .ADDR_W (ADDR_W), .LEN_W (LEN_W), .POLL_W (POLL_W)
  ) u0 (
    .clk (clk), .rstN (rstN),
    .postValid (postValid), .postAddr (postAddr), .postLen (postLen),
    .postReady (postReady),
    .cfgPollInterval (cfgPollInterval), .cfgIrqRefill (cfgIrqRefill),
    .cfgLowWater (cfgLowWater), .irqClr (irqClr), .irq (irq),
    .txReqValid (txReqValid), .txReqAddr (txReqAddr), .txReqLen (txReqLen),
    .txDone (txDone)
  );

  function automatic logic [ADDR_W-1:0] addrOf(input int s);
    return ADDR_W'(32'h1000 + s * 3);
  endfunction

  function automatic logic [LEN_W-1:0] lenOf(input int s);
    return LEN_W'(s * 7 + 1);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      summary();
      $finish;
    end
  end

  // all tasks start and end just after a falling edge
  task automatic postOne(input int s);
    chk(postReady == 1'b1, "R2", "postReady before post", int'(postReady), 1);
    postAddr  = addrOf(s);
    postLen   = lenOf(s);
    postValid = 1'b1;
    @(negedge clk);
    postValid = 1'b0;
  endtask

  task automatic waitReq();
    int n = 0;
    while (!txReqValid && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishReq(input int s, input int hold);
    chk(txReqValid == 1'b1, "R4", "request present", int'(txReqValid), 1);
    chk(txReqAddr == addrOf(s), "R4", "request address", int'(txReqAddr), int'(addrOf(s)));
    chk(txReqLen == lenOf(s), "R4", "request length", int'(txReqLen), int'(lenOf(s)));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(txReqValid && txReqAddr == addrOf(s), "R4", "request held",
          int'(txReqAddr), int'(addrOf(s)));
    end
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  task automatic clearIrq();
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(postReady == 1'b1, "R1", "postReady", int'(postReady), 1);
    chk(txReqValid == 1'b0, "R1", "txReqValid", int'(txReqValid), 0);
    chk(irq == 1'b0, "R1", "irq", int'(irq), 0);

    // R6/R7/R9/R2: sweep poll interval, measure idle gap, wraps ring
    cfgIrqRefill = 1'b0;
    for (int iv = 2; iv <= 33; iv++) begin
      int gap;
      cfgPollInterval = POLL_W'(iv);
      postOne(seq);
      waitReq();
      finishReq(seq, iv % 3);
      chk(irq == 1'b1, "R7", "irq after completion", int'(irq), 1);
      irqClr    = 1'b1;
      postAddr  = addrOf(seq + 1);
      postLen   = lenOf(seq + 1);
      postValid = 1'b1;
      gap = 0;
      while (!txReqValid && gap < 500) begin
        gap++;
        @(negedge clk);
        postValid = 1'b0;
        irqClr    = 1'b0;
      end
      chk(gap == iv, "R6", "idle gap", gap, iv);
      chk(irq == 1'b0, "R9", "irq after clear", int'(irq), 0);
      finishReq(seq + 1, 0);
      chk(irq == 1'b1, "R7", "irq second completion", int'(irq), 1);
      clearIrq();
      seq += 2;
    end

    // R5: back-to-back completions leave no gap
    cfgPollInterval = POLL_W'(20);
    for (int k = 0; k < 3; k++) postOne(seq + k);
    waitReq();
    finishReq(seq, 1);
    chk(txReqValid == 1'b1, "R5", "no gap after 1st", int'(txReqValid), 1);
    finishReq(seq + 1, 0);
    chk(txReqValid == 1'b1, "R5", "no gap after 2nd", int'(txReqValid), 1);
    finishReq(seq + 2, 0);
    chk(txReqValid == 1'b0, "R5", "idle when empty", int'(txReqValid), 0);
    clearIrq();
    seq += 3;

    // R3: full ring refuses extra post
    cfgPollInterval = POLL_W'(3);
    for (int k = 0; k < DEPTH; k++) postOne(seq + k);
    chk(postReady == 1'b0, "R3", "postReady when full", int'(postReady), 0);
    postAddr  = 16'hBEEF;
    postLen   = 8'hEE;
    postValid = 1'b1;
    @(negedge clk);
    postValid = 1'b0;
    chk(postReady == 1'b0, "R3", "still full", int'(postReady), 0);
    for (int k = 0; k < DEPTH; k++) begin
      waitReq();
      finishReq(seq + k, 1);
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (txReqValid) chk(1'b0, "R3", "refused post was sent", int'(txReqAddr), 0);
    end
    chk(postReady == 1'b1, "R3", "ready after drain", int'(postReady), 1);
    seq += DEPTH;
    postOne(seq);
    waitReq();
    finishReq(seq, 0);
    seq++;
    clearIrq();

    // R8: low-water sweep in refill mode
    cfgIrqRefill = 1'b1;
    for (int lw = 0; lw <= DEPTH; lw++) begin
      cfgLowWater = CNT_W'(lw);
      for (int k = 0; k < DEPTH; k++) postOne(seq + k);
      for (int k = 1; k <= DEPTH; k++) begin
        bit expIrq;
        waitReq();
        finishReq(seq + k - 1, 0);
        expIrq = (DEPTH - k == lw);
        chk(irq == expIrq, "R8", "low-water irq", int'(irq), int'(expIrq));
        if (irq) clearIrq();
      end
      seq += DEPTH;
    end

    // R9: completion wins over simultaneous clear
    cfgIrqRefill    = 1'b0;
    cfgPollInterval = POLL_W'(20);
    postOne(seq);
    postOne(seq + 1);
    waitReq();
    finishReq(seq, 0);
    chk(irq == 1'b1, "R9", "pending before race", int'(irq), 1);
    chk(txReqAddr == addrOf(seq + 1), "R5", "next presented", int'(txReqAddr),
        int'(addrOf(seq + 1)));
    txDone = 1'b1;
    irqClr = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
    irqClr = 1'b0;
    chk(irq == 1'b1, "R9", "set wins over clear", int'(irq), 1);
    clearIrq();
    chk(irq == 1'b0, "R9", "cleared", int'(irq), 0);
    seq += 2;

    // R10: stray done while idle is ignored
    cfgPollInterval = POLL_W'(4);
    txDone = 1'b1;
    repeat (3) @(negedge clk);
    txDone = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10", "no irq from stray done", int'(irq), 0);
    chk(txReqValid == 1'b0, "R10", "still idle", int'(txReqValid), 0);
    postOne(seq);
    waitReq();
    finishReq(seq, 0);
    chk(irq == 1'b1, "R7", "irq after real done", int'(irq), 1);
    seq++;

    summary();
    $finish;
  end

endmodule